// File: doc/BRIEF.md
# I2C Address-Decoded Full-Erase Front End

This block sits on an I2C bus in front of a small nonvolatile memory with two sectors. It watches the bus lines, finds start and stop conditions, shifts in the first byte of each transfer, and decides whether to acknowledge it. One device answers at two bus addresses. The upper four address bits must equal a configured device prefix. When the three low address bits equal the configured access value, the transfer is an ordinary read or write access. When they are all ones and the direction bit says write, the transfer asks for the whole memory to be erased.

An accepted erase request is only held as pending until the master ends the transfer with a stop condition. At that stop the block sends one erase pulse to the memory back end and stays busy until the back end reports completion. While it is busy it answers no address at all, so a master polls for completion by repeating the address until it is acknowledged. A write-protect input blocks the erase address. Data bytes that follow the address are handled by other logic.

Top module: `i2c_erase_gate`

## Requirements
- R1: After reset, `sda_oe`, `busy`, `erase_start` and `acc_grant` are all 0.
- R2: An address byte whose upper four address bits (byte bits 7..4) differ from `dev_prefix` gets no acknowledge, and `sda_oe` stays 0 until the next start condition.
- R3: An address byte whose seven address bits equal {`dev_prefix`, `acc_low`} is acknowledged in either direction (byte bit 0: 0 = write, 1 = read), provided `acc_low` is not 3'b111. The same event gives a one-cycle `acc_grant` pulse, and `acc_rnw` holds the direction bit.
- R4: When the low address bits (byte bits 3..1) are 3'b111 with the direction bit 0 and the prefix matches, the address is acknowledged as an erase request if `wp` is 0 and the block is not busy. The same address with the direction bit 1 is not acknowledged.
- R5: An accepted erase request produces exactly one `erase_start` pulse, one clock wide, only after the stop condition that ends the transfer. Acknowledging the address alone produces no pulse.
- R6: While `wp` is 1, the erase address gets no acknowledge and no `erase_start` follows the stop. Normal access is still acknowledged.
- R7: `busy` rises with `erase_start` and falls after `erase_done` is 1. While `busy` is 1, no address is acknowledged, including the erase address and the normal address.
- R8: A repeated start condition that arrives after an accepted erase address and before any stop cancels the pending erase, so no `erase_start` follows.
- R9: The acknowledge is driven (`sda_oe` = 1) only during the ninth SCL clock. It begins after the eighth falling edge of SCL and ends after the ninth falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| dev_prefix | input | 4 | Configured upper address bits of the device |
| acc_low | input | 3 | Configured low address bits for normal access (not 3'b111) |
| wp | input | 1 | Write protect; 1 blocks the erase request |
| erase_done | input | 1 | Back end reports that the erase has finished |
| erase_start | output | 1 | One-cycle erase request to the back end |
| busy | output | 1 | Erase in progress; every address is refused |
| acc_grant | output | 1 | One-cycle pulse when a normal access is acknowledged |
| acc_rnw | output | 1 | Direction bit of the last received address byte |

## Verification
The assertions check on every cycle that:
- `erase_start` is one clock wide and comes only in the cycle after a detected stop.
- An erase never starts while a previous one is busy.
- `busy` holds until `erase_done`.
- The acknowledge never appears while busy.
- The acknowledge only starts while the synchronized clock line is low.

Only the bench's scenarios can show the rest, because these depend on full bus sequences:
- Which address patterns are acknowledged.
- That write protect and the read direction refuse the erase address.
- That a repeated start cancels a pending erase.
- That acknowledge polling succeeds again once the back end reports completion.

// File: rtl/erase_gate_pkg.sv
package erase_gate_pkg;

  localparam logic [2:0] ERASE_LOW_CODE = 3'b111;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_DECIDE,
    PH_ACK,
    PH_IGNORE
  } phase_t;

endpackage

// File: rtl/egc_bus_sync.sv
module egc_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);

  logic [STAGES-1:0] scl_q;
  logic [STAGES-1:0] sda_q;
  logic              scl_d;
  logic              sda_d;

  // Synchronizer chains reset to the idle (high) bus level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;

endmodule

// File: rtl/egc_addr_frame.sv
module egc_addr_frame
  import erase_gate_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int LOW_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda_s,
  input  logic [ID_W-1:0]  dev_prefix,
  input  logic [LOW_W-1:0] acc_low,
  input  logic             wp,
  input  logic             busy,
  output logic             sda_oe,
  output logic             erase_arm,
  output logic             acc_grant,
  output logic             acc_rnw
);

  localparam int ADDR_W = ID_W + LOW_W;
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  phase_t            phase_q, phase_n;
  logic [BYTE_W-1:0] shift_q, shift_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;

  logic [ID_W-1:0]   rx_prefix;
  logic [LOW_W-1:0]  rx_low;
  logic              rx_rnw;
  logic              prefix_ok;
  logic              erase_hit;
  logic              norm_hit;

  assign rx_prefix = shift_q[BYTE_W-1 -: ID_W];
  assign rx_low    = shift_q[LOW_W:1];
  assign rx_rnw    = shift_q[0];
  assign prefix_ok = (rx_prefix == dev_prefix);
  assign erase_hit = prefix_ok && (rx_low == ERASE_LOW_CODE) && !rx_rnw && !wp && !busy;
  assign norm_hit  = prefix_ok && (rx_low == acc_low) && (acc_low != ERASE_LOW_CODE) && !busy;

  always_comb begin
    phase_n   = phase_q;
    shift_n   = shift_q;
    cnt_n     = cnt_q;
    erase_arm = 1'b0;
    acc_grant = 1'b0;
    if (start_det) begin
      phase_n = PH_ADDR;
      cnt_n   = '0;
    end else if (stop_det) begin
      phase_n = PH_IDLE;
    end else begin
      unique case (phase_q)
        PH_ADDR: begin
          if (scl_rise) begin
            shift_n = {shift_q[BYTE_W-2:0], sda_s};
            cnt_n   = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) phase_n = PH_DECIDE;
          end
        end
        PH_DECIDE: begin
          if (scl_fall) begin
            if (erase_hit || norm_hit) begin
              phase_n   = PH_ACK;
              erase_arm = erase_hit;
              acc_grant = norm_hit;
            end else begin
              phase_n = PH_IGNORE;
            end
          end
        end
        PH_ACK: begin
          if (scl_fall) phase_n = PH_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_n;
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
    end
  end

  assign sda_oe  = (phase_q == PH_ACK);
  assign acc_rnw = rx_rnw;

endmodule

// File: rtl/egc_erase_track.sv
module egc_erase_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_det,
  input  logic stop_det,
  input  logic erase_arm,
  input  logic erase_done,
  output logic erase_start,
  output logic busy
);

  logic pend_q, pend_n;
  logic go_q, go_n;
  logic busy_q, busy_n;

  always_comb begin
    pend_n = pend_q;
    go_n   = 1'b0;
    busy_n = busy_q;
    if (erase_arm) begin
      pend_n = 1'b1;
    end else if (start_det) begin
      pend_n = 1'b0;
    end else if (stop_det) begin
      pend_n = 1'b0;
      go_n   = pend_q;
    end
    if (go_n) begin
      busy_n = 1'b1;
    end else if (erase_done) begin
      busy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      go_q   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      go_q   <= go_n;
      busy_q <= busy_n;
    end
  end

  assign erase_start = go_q;
  assign busy        = busy_q;

endmodule

// File: rtl/i2c_erase_gate.sv
module i2c_erase_gate #(
  parameter int ID_W        = 4,
  parameter int LOW_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe,
  input  logic [ID_W-1:0]  dev_prefix,
  input  logic [LOW_W-1:0] acc_low,
  input  logic             wp,
  input  logic             erase_done,
  output logic             erase_start,
  output logic             busy,
  output logic             acc_grant,
  output logic             acc_rnw
);

  logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic erase_arm;

  egc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall)
  );

  egc_addr_frame #(.ID_W(ID_W), .LOW_W(LOW_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_det  (start_det),
    .stop_det   (stop_det),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .sda_s      (sda_s),
    .dev_prefix (dev_prefix),
    .acc_low    (acc_low),
    .wp         (wp),
    .busy       (busy),
    .sda_oe     (sda_oe),
    .erase_arm  (erase_arm),
    .acc_grant  (acc_grant),
    .acc_rnw    (acc_rnw)
  );

  egc_erase_track u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .erase_arm   (erase_arm),
    .erase_done  (erase_done),
    .erase_start (erase_start),
    .busy        (busy)
  );

endmodule

// File: rtl/i2c_erase_gate_chk.sv
module i2c_erase_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic erase_start,
  input logic erase_done,
  input logic busy,
  input logic stop_det,
  input logic scl_s
);

  AST_ERASE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start); // R5

  AST_ERASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> $past(stop_det)); // R5

  AST_NO_ERASE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> !$past(busy)); // R7

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !erase_done) |=> busy); // R7

  AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe); // R7

  AST_ACK_ON_LOW_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s); // R9

endmodule

bind i2c_erase_gate i2c_erase_gate_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_oe      (sda_oe),
  .erase_start (erase_start),
  .erase_done  (erase_done),
  .busy        (busy),
  .stop_det    (stop_det),
  .scl_s       (scl_s)
);

// File: tb/tb_i2c_erase_gate.sv
`timescale 1ns/1ps
module tb_i2c_erase_gate;

  localparam int QTR = 100; // quarter SCL period in ns (10 clocks)

  logic       clk, rst_n;
  logic       scl_m, sda_m;
  logic       sda_w;
  logic       sda_oe, erase_start, busy, acc_grant, acc_rnw;
  logic [3:0] dev_prefix;
  logic [2:0] acc_low;
  logic       wp, erase_done;

  int total = 0;
  int bad   = 0;
  int erase_cnt = 0;
  int erase_wide = 0;
  int grant_cnt = 0;
  bit obs_ack;
  bit obs_early;
  bit obs_rnw;
  bit done_flag = 0;
  event ack_ev;

  typedef struct { bit ack; string tag; } exp_t;
  exp_t exp_q[$];

  assign sda_w = sda_m & ~sda_oe;

  i2c_erase_gate dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_w), .sda_oe(sda_oe),
    .dev_prefix(dev_prefix), .acc_low(acc_low), .wp(wp), .erase_done(erase_done),
    .erase_start(erase_start), .busy(busy), .acc_grant(acc_grant), .acc_rnw(acc_rnw)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Pulse monitor on the falling clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (erase_start) begin
        erase_wide++;
        if (erase_wide == 1) erase_cnt++;
      end else begin
        erase_wide = 0;
      end
      if (acc_grant) grant_cnt++;
    end
  end

  // Scoreboard monitor: compare each observed acknowledge with the queued expectation
  initial begin
    forever begin
      @(ack_ev);
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard empty", int'(obs_ack), -1);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(obs_ack == e.ack, e.tag, int'(obs_ack), int'(e.ack));
        check(obs_early == 1'b0, "R9 ack early", int'(obs_early), 0);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; #(QTR);
    scl_m = 1'b1; #(QTR);
    sda_m = 1'b0; #(QTR);
    scl_m = 1'b0; #(QTR);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #(QTR);
    scl_m = 1'b1; #(QTR);
    sda_m = 1'b1; #(2*QTR);
  endtask

  // Driver: push the expected acknowledge (1 = acked), then send the byte
  task automatic send_addr(input logic [7:0] b, input bit exp_ack, input string tag);
    exp_t e;
    e.ack = exp_ack;
    e.tag = tag;
    exp_q.push_back(e);
    obs_early = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #(QTR);
      scl_m = 1'b1; #(QTR);
      if (sda_oe) obs_early = 1'b1;
      #(QTR);
      scl_m = 1'b0; #(QTR);
    end
    sda_m = 1'b1; #(QTR);
    scl_m = 1'b1; #(QTR);
    obs_ack = ~sda_w;
    obs_rnw = acc_rnw;
    ->ack_ev;
    #(QTR);
    scl_m = 1'b0; #(QTR);
    #(QTR);
    check(sda_oe == 1'b0, {tag, " R9 release"}, int'(sda_oe), 0);
  endtask

  task automatic end_erase();
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(2_000_000);
    if (!done_flag) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int ec, gc;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    dev_prefix = 4'b1010; acc_low = 3'b010; wp = 1'b0; erase_done = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sda_oe == 0 && busy == 0 && erase_start == 0 && acc_grant == 0, "R1 reset",
          {sda_oe, busy, erase_start, acc_grant}, 0);

    // R3: normal write and read
    gc = grant_cnt;
    bus_start(); send_addr({7'b1010010, 1'b0}, 1, "R3 normal write");
    check(obs_rnw == 0, "R3 rnw write", obs_rnw, 0);
    bus_stop();
    check(grant_cnt == gc + 1, "R3 grant pulse", grant_cnt - gc, 1);
    check(erase_cnt == 0, "R3 no erase", erase_cnt, 0);
    bus_start(); send_addr({7'b1010010, 1'b1}, 1, "R3 normal read");
    check(obs_rnw == 1, "R3 rnw read", obs_rnw, 1);
    bus_stop();

    // R2: prefix mismatch, line stays released afterwards
    bus_start(); send_addr({7'b1011010, 1'b0}, 0, "R2 prefix mismatch");
    send_addr(8'h00, 0, "R2 stays released");
    bus_stop();
    bus_start(); send_addr({7'b1010011, 1'b0}, 0, "R2 low mismatch");
    bus_stop();

    // R4/R5: erase request, pulse only after stop
    ec = erase_cnt;
    bus_start(); send_addr({7'b1010111, 1'b0}, 1, "R4 erase ack");
    #(4*QTR);
    check(erase_cnt == ec, "R5 no pulse before stop", erase_cnt - ec, 0);
    bus_stop();
    check(erase_cnt == ec + 1, "R5 one pulse after stop", erase_cnt - ec, 1);
    check(busy == 1, "R7 busy set", busy, 1);

    // R7: polling while busy gets no acknowledge
    bus_start(); send_addr({7'b1010111, 1'b0}, 0, "R7 erase poll busy");
    bus_stop();
    bus_start(); send_addr({7'b1010010, 1'b0}, 0, "R7 normal busy");
    bus_stop();
    check(erase_cnt == ec + 1, "R7 no extra pulse", erase_cnt - ec, 1);
    end_erase();
    check(busy == 0, "R7 busy cleared", busy, 0);

    // R8: repeated start cancels pending erase
    ec = erase_cnt;
    bus_start(); send_addr({7'b1010111, 1'b0}, 1, "R8 erase ack");
    bus_start(); send_addr({7'b1010010, 1'b1}, 1, "R8 repeated start read");
    bus_stop();
    check(erase_cnt == ec, "R8 cancelled", erase_cnt - ec, 0);
    check(busy == 0, "R8 not busy", busy, 0);

    // R4: erase address with read direction
    bus_start(); send_addr({7'b1010111, 1'b1}, 0, "R4 erase read nack");
    bus_stop();
    check(erase_cnt == ec, "R4 read no erase", erase_cnt - ec, 0);

    // R6: write protect
    wp = 1'b1;
    bus_start(); send_addr({7'b1010111, 1'b0}, 0, "R6 wp erase nack");
    bus_stop();
    check(erase_cnt == ec, "R6 no erase", erase_cnt - ec, 0);
    check(busy == 0, "R6 not busy", busy, 0);
    bus_start(); send_addr({7'b1010010, 1'b0}, 1, "R6 normal with wp");
    bus_stop();
    wp = 1'b0;

    // R5: a second full erase cycle, pulse width
    ec = erase_cnt;
    bus_start(); send_addr({7'b1010111, 1'b0}, 1, "R5 erase again");
    bus_stop();
    check(erase_cnt == ec + 1, "R5 second pulse", erase_cnt - ec, 1);
    check(erase_wide == 0, "R5 pulse ended", erase_wide, 0);
    end_erase();
    bus_start(); send_addr({7'b1010010, 1'b0}, 1, "R7 ack after done");
    bus_stop();

    #(4*QTR);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done_flag = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule